// File: doc/BRIEF.md
# Peak-Power-Limited Action Scheduler

This block decides, every clock cycle, which of up to eight guarded actions may fire. The actions are known not to conflict with one another. Each one has a fixed power cost, and the set that fires together must stay under one peak-power budget. The caller presents a vector of ready flags. In the same cycle, the block returns a vector of fire grants and the summed cost of the granted set.

The choice for every possible ready vector is worked out during elaboration from a cost parameter array and the budget. The results form a combinational lookup table of 2^N entries, and the ready vector indexes that table directly. Priority runs from action index 0, which is the highest, up to index N-1.

When the ready set is over budget, the lowest-priority ready actions are held back first. A held-back action is expected to stay ready and fire in a later cycle, because the surrounding logic tolerates added latency. A registered per-action pending flag records each action that was ready but held back in the previous cycle.

Top module: `pwr_sched`

## Requirements
- R1: A grant bit is set only for an action whose ready bit is set, so a zero ready vector gives a zero grant vector.
- R2: When the total cost of all ready actions is at or below the budget, the grant vector equals the ready vector.
- R3: When the ready set is over budget, the grant is the longest run of ready actions, taken in priority order from index 0 upward, whose total cost fits the budget. Every ready action after that run is held back.
- R4: The reported grant cost never exceeds the budget, except when exactly one action is granted.
- R5: When the highest-priority ready action costs more than the budget by itself, it is granted alone.
- R6: Any nonzero ready vector yields a nonzero grant vector.
- R7: `grant_cost` equals the sum of the costs of the granted actions.
- R8: After each rising clock edge, `pending[i]` is 1 exactly when action i was ready and not granted in the cycle before that edge. It stays set across repeated suppression and clears once the action is granted or drops its ready flag.
- R9: While reset is asserted (active low, asynchronous), `pending` is all zeros.
- R10: `grant` and `grant_cost` are combinational functions of `ready`, valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | input | N_ACT | Ready flag per action, bit 0 is the highest priority |
| grant | output | N_ACT | Fire grant per action, same cycle as ready |
| grant_cost | output | COST_W+clog2(N_ACT+1) | Summed cost of the granted actions |
| pending | output | N_ACT | Registered flags for actions held back in the previous cycle |

## Verification
The assertions check several properties on every cycle:
- grants stay inside the ready set;
- a nonzero ready set never gets an empty grant;
- the reported cost stays within budget unless one action fires alone;
- no held-back action outranks a granted one;
- a pending flag never survives a cycle in which its action was granted.

Only the bench scenarios can show two further behaviours, because both depend on the actual cost values. One is that the exact subset chosen is the longest fitting priority run. The other is that the reported cost equals the true sum. The scenarios also cover an oversized action being granted alone and pending flags persisting across repeated suppression.

// File: rtl/pwr_sched_pkg.sv
package pwr_sched_pkg;

  localparam int MAX_ACT    = 16;
  localparam int MAX_COST_W = 16;
  localparam int COST_VEC_W = MAX_ACT * MAX_COST_W;

  typedef logic [MAX_ACT-1:0]    act_mask_t;
  typedef logic [COST_VEC_W-1:0] cost_vec_t;

  // cost of action idx, from a packed array of w-bit fields
  function automatic int unsigned cost_at(cost_vec_t costs, int w, int idx);
    int unsigned c;
    c = 0;
    for (int b = 0; b < w; b++) begin
      if (costs[idx*w + b]) c = c | (32'd1 << b);
    end
    return c;
  endfunction

  // budget-limited priority pick: walk from index 0, stop at first misfit
  function automatic act_mask_t pick_subset(act_mask_t rdy, cost_vec_t costs,
                                            int n, int w, int unsigned budget);
    act_mask_t   m;
    int unsigned acc;
    bit          halted;
    m      = '0;
    acc    = 0;
    halted = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (rdy[i] && !halted) begin
        if (acc + cost_at(costs, w, i) <= budget) begin
          m[i] = 1'b1;
          acc  = acc + cost_at(costs, w, i);
        end else begin
          halted = 1'b1;
        end
      end
    end
    // oversized leader: grant it alone so it cannot starve
    if (m == '0) begin
      for (int i = n - 1; i >= 0; i--) begin
        if (rdy[i]) m = act_mask_t'(1) << i;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/psched_rom.sv
module psched_rom
  import pwr_sched_pkg::*;
#(
  parameter int          N_ACT  = 8,
  parameter int          COST_W = 6,
  parameter cost_vec_t   COSTS  = '0,
  parameter int unsigned BUDGET = 30
) (
  input  logic [N_ACT-1:0] ready,
  output logic [N_ACT-1:0] grant
);

  localparam int DEPTH = 1 << N_ACT;

  logic [N_ACT-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam act_mask_t PICK = pick_subset(act_mask_t'(e), COSTS, N_ACT, COST_W, BUDGET);
    assign rom[e] = PICK[N_ACT-1:0];
  end

  assign grant = rom[ready];

endmodule

// File: rtl/psched_cost.sv
module psched_cost #(
  parameter int                    N_ACT   = 8,
  parameter int                    COST_W  = 6,
  parameter int                    SUM_W   = 10,
  parameter logic [N_ACT*COST_W-1:0] ACT_COST = '0
) (
  input  logic [N_ACT-1:0] grant,
  output logic [SUM_W-1:0] total
);

  logic [SUM_W-1:0] term [N_ACT];

  for (genvar i = 0; i < N_ACT; i++) begin : g_term
    localparam logic [COST_W-1:0] C = ACT_COST[i*COST_W +: COST_W];
    assign term[i] = grant[i] ? SUM_W'(C) : '0;
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < N_ACT; i++) total = total + term[i];
  end

endmodule

// File: rtl/psched_pend.sv
module psched_pend #(
  parameter int N_ACT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ACT-1:0] held,
  output logic [N_ACT-1:0] pending
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= held;
  end

endmodule

// File: rtl/pwr_sched.sv
module pwr_sched
  import pwr_sched_pkg::*;
#(
  parameter int                      N_ACT    = 8,
  parameter int                      COST_W   = 6,
  parameter logic [N_ACT*COST_W-1:0] ACT_COST = {6'd9, 6'd5, 6'd15, 6'd8,
                                                 6'd12, 6'd6, 6'd40, 6'd10},
  parameter int unsigned             BUDGET   = 30,
  localparam int                     SUM_W    = COST_W + $clog2(N_ACT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ACT-1:0] ready,
  output logic [N_ACT-1:0] grant,
  output logic [SUM_W-1:0] grant_cost,
  output logic [N_ACT-1:0] pending
);

  localparam cost_vec_t COST_EXT = {{(COST_VEC_W - N_ACT*COST_W){1'b0}}, ACT_COST};

  // named internal events for the checker
  logic [N_ACT-1:0] suppressed;
  logic             over_budget;
  logic             lone_oversize;

  psched_rom #(
    .N_ACT(N_ACT), .COST_W(COST_W), .COSTS(COST_EXT), .BUDGET(BUDGET)
  ) u_rom (
    .ready(ready),
    .grant(grant)
  );

  psched_cost #(
    .N_ACT(N_ACT), .COST_W(COST_W), .SUM_W(SUM_W), .ACT_COST(ACT_COST)
  ) u_cost (
    .grant(grant),
    .total(grant_cost)
  );

  assign suppressed    = ready & ~grant;
  assign over_budget   = grant_cost > SUM_W'(BUDGET);
  assign lone_oversize = over_budget && ($countones(grant) == 1);

  psched_pend #(.N_ACT(N_ACT)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .held   (suppressed),
    .pending(pending)
  );

endmodule

// File: rtl/psched_chk.sv
module psched_chk #(
  parameter int N_ACT = 8,
  parameter int SUM_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_ACT-1:0] ready,
  input logic [N_ACT-1:0] grant,
  input logic [N_ACT-1:0] pending,
  input logic [N_ACT-1:0] suppressed,
  input logic             over_budget,
  input logic             lone_oversize
);

  // no held-back action may outrank a granted one
  logic order_ok;
  always_comb begin
    order_ok = 1'b1;
    for (int i = 0; i < N_ACT; i++)
      for (int j = i + 1; j < N_ACT; j++)
        if (suppressed[i] && grant[j]) order_ok = 1'b0;
  end

  // R1
  grant_in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~ready) == '0);

  // R6
  nonempty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready != '0) |-> (grant != '0));

  // R4
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_budget |-> lone_oversize);

  // R3
  priority_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_ok);

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((pending & $past(grant)) == '0));

  // R9
  always @(posedge clk) begin
    if (!rst_n) pend_reset_chk: assert (pending == '0);
  end

endmodule

bind pwr_sched psched_chk #(.N_ACT(N_ACT), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .grant(grant), .pending(pending),
  .suppressed(suppressed), .over_budget(over_budget), .lone_oversize(lone_oversize)
);

// File: tb/sim_pwr_sched.sv
module sim_pwr_sched;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int SW         = 10;
  localparam int BUD        = 30;
  localparam int COST [N]   = '{10, 40, 6, 12, 8, 15, 5, 9};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ready = '0;
  logic [N-1:0]  grant;
  logic [SW-1:0] grant_cost;
  logic [N-1:0]  pending;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] exp_pend = '0;

  pwr_sched u0 (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .grant(grant), .grant_cost(grant_cost), .pending(pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sum_of(logic [N-1:0] m);
    int s = 0;
    for (int i = 0; i < N; i++) if (m[i]) s += COST[i];
    return s;
  endfunction

  // drop lowest-priority ready action while over budget and more than one left
  function automatic logic [N-1:0] model(logic [N-1:0] r);
    logic [N-1:0] m = r;
    while (sum_of(m) > BUD && $countones(m) > 1) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (m[i]) begin m[i] = 1'b0; break; end
      end
    end
    return m;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one ready vector at negedge; check pending, then grant and cost
  task automatic apply(logic [N-1:0] r, string req);
    logic [N-1:0] g;
    @(negedge clk);
    check("R8 pending", int'(pending), int'(exp_pend));
    ready = r;
    #1;
    g = model(r);
    check({req, " grant"}, int'(grant), int'(g));
    check("R7 cost", int'(grant_cost), sum_of(g));
    exp_pend = r & ~g;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset pending", int'(pending), 0);
    rst_n = 1'b1;

    apply(8'h00, "R1 idle");
    apply(8'h44, "R2 within budget");       // 6+5 = 11, unchanged
    apply(8'h05, "R2 within budget");       // 10+6
    apply(8'hFD, "R3 prefix");              // 10+6+12 = 28, then 8 misfits
    apply(8'hFD, "R3 repeat suppression");  // pending stays 0xF0
    apply(8'h0D, "R8 retry granted");
    apply(8'h02, "R5 oversized alone");     // cost 40
    apply(8'hFE, "R5 oversized leader");
    apply(8'hFF, "R3 top fits only");       // 10, then 40 misfits
    apply(8'hFF, "R3 hold");
    apply(8'h00, "R8 ready drop clears");
    apply(8'h80, "R6 lowest alone");

    for (int k = 0; k < 400; k++) apply(N'($urandom), "R10 random");

    apply(8'h00, "R1 final");
    @(negedge clk);
    check("R8 pending final", int'(pending), int'(exp_pend));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule